// File: doc/BRIEF.md
# Multiplexed Pin Function Controller

This block decides, pin by pin, which on-chip source owns each pin of a 22-pin I/O port. A pin can be a general-purpose port bit, one bit of an external data bus, the serial receive or transmit line, or an alternate function whose direction the port direction register sets. For every pin the block drives the output enable, the output data and a two-bit source code. It also returns the pin level to the peripheral that owns the pin.

Software programs the block through a plain synchronous 16-bit register port. Each pin's two-bit function code is split between two registers: the high bit sits in one and the low bit at the same bit position in the other. Pins 0 to 15 live in the lower register of each pair and pins 16 to 21 in the upper one. A boot-mode input selects the reset state of the data bus pins.

The register port has no back-pressure: a write is accepted on every clock edge where `reg_we` is high, and a read is a combinational decode of `reg_addr`. The pin, bus and serial signals are plain level signals with no handshake.

Top module: `pin_function_ctrl`

## Requirements
- R1: On reset all registers and the error flag read 0. The only exception is the low function bits of the bus-capable pins (pins 0 to BUS_W-1), which reset to 1 when `boot_ext8` is high during reset, so those pins start in bus mode (source code 01).
- R2: The high function bit of pin i is bit i of register 0 (pins 0-15) or bit i-16 of register 1. The low bit sits at the same position in register 2 or 3. Code 00 is port mode: `pin_sel`=00, `pin_out` is the output latch bit (register 6/7), and `pin_oe` is the direction bit.
- R3: Code 01 on a pin below BUS_W gives `pin_sel`=01, `pin_out`=`bus_dout[i]` and `pin_oe`=`bus_wr`, the direction bit is ignored, and `bus_din[i]` follows the pin. When a pin is not in bus mode its `bus_din` bit is 0. On pins at or above BUS_W, code 01 acts as port mode.
- R4: Code 10 on pin 1 drives `ser_txd` with `pin_oe`=1. Code 10 on pin 0 gives `pin_oe`=0 and `pin_out`=0. The direction bit is ignored in both cases. `ser_rxd` follows pin 0 while pin 0 is in code 10 and is 1 otherwise.
- R5: Code 10 on any other pin selects the alternate function: `pin_sel`=10, `pin_out`=`alt_dout[i]`, `pin_oe` is the direction bit and `alt_din[i]` follows the pin. When a pin is not in this function its `alt_din` bit is 0.
- R6: Code 11 is forbidden. The pin behaves as in port mode with `pin_sel`=00. While any pin holds code 11, the error flag (bit 0 of register 8) is set on the next edge. The flag stays set until 1 is written to that bit while no pin holds code 11. Writing 0 leaves it unchanged.
- R7: A direction bit of 1 makes a port-mode pin drive (`pin_oe`=1) and 0 makes it an input.
- R8: The upper registers (1, 3, 5 and 7) store only bits 5:0. Bits 15:6 read as 0 whatever was written.
- R9: A write takes effect on the clock edge where `reg_we` is high. Until that edge a read returns the old value, and after it the new one.
- R10: A read of register 6/7 returns the output latch for pins whose direction bit is 1, and for pins whose direction bit is 0 the pin level delayed by SYNC_STAGES clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_ext8 | input | 1 | Boot mode: 8-bit external bus with internal ROM disabled |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| pin_in | input | 22 | Pin levels from the pads |
| pin_oe | output | 22 | Per-pin output enable |
| pin_out | output | 22 | Per-pin output data |
| pin_sel | output | 44 | Per-pin source code, two bits per pin |
| bus_wr | input | 1 | Data bus is in a write cycle |
| bus_dout | input | 8 | Data bus write data |
| bus_din | output | 8 | Data bus read data from the pins |
| ser_txd | input | 1 | Serial transmit line |
| ser_rxd | output | 1 | Serial receive line |
| alt_dout | input | 22 | Alternate function output data |
| alt_din | output | 22 | Alternate function input data |

## Verification
The assertions check four things on every cycle: the source code never shows 11, the transmit pin always drives while it is in serial mode, the receive pin never drives in serial mode, and pins above the bus width never pass data to the bus. They also check that the error flag sets and then holds, that a direction write lands on the next edge, and that the reserved upper bits always read 0. The bench's scenarios cover the rest. They show the full per-pin enable and data mapping across mixes of functions, the reset values under both boot modes, the synchroniser delay in port readback, and the clear-while-still-forbidden case of the error flag.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    FN_PORT = 2'b00,
    FN_BUS  = 2'b01,
    FN_SER  = 2'b10,
    FN_BAD  = 2'b11
  } pin_fn_e;

  localparam logic [3:0] A_SELH_LO = 4'd0;
  localparam logic [3:0] A_SELH_UP = 4'd1;
  localparam logic [3:0] A_SELL_LO = 4'd2;
  localparam logic [3:0] A_SELL_UP = 4'd3;
  localparam logic [3:0] A_DIR_LO  = 4'd4;
  localparam logic [3:0] A_DIR_UP  = 4'd5;
  localparam logic [3:0] A_OUT_LO  = 4'd6;
  localparam logic [3:0] A_OUT_UP  = 4'd7;
  localparam logic [3:0] A_STATUS  = 4'd8;

  localparam int REG_W = 16;

endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
  parameter int W      = 22,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pfc_regs.sv
module pfc_regs
  import pfc_pkg::*;
#(
  parameter int NUM_PINS = 22,
  parameter int BUS_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boot_ext8,
  input  logic                we,
  input  logic [3:0]          addr,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rdata,
  input  logic [NUM_PINS-1:0] port_view,
  output logic [NUM_PINS-1:0] sel_hi,
  output logic [NUM_PINS-1:0] sel_lo,
  output logic [NUM_PINS-1:0] dir,
  output logic [NUM_PINS-1:0] outl,
  output logic                err
);

  localparam int UPW = NUM_PINS - REG_W;

  logic [NUM_PINS-1:0] hi_q, lo_q, dir_q, out_q;
  logic [NUM_PINS-1:0] lo_rst;
  logic                err_q;
  logic                bad_any;
  logic                clr_req;

  always_comb begin
    lo_rst = '0;
    if (boot_ext8) lo_rst[BUS_W-1:0] = '1;
  end

  assign bad_any = |(hi_q & lo_q);
  assign clr_req = we && (addr == A_STATUS) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= lo_rst;
      dir_q <= '0;
      out_q <= '0;
    end else if (we) begin
      case (addr)
        A_SELH_LO: hi_q[REG_W-1:0]     <= wdata;
        A_SELH_UP: hi_q[NUM_PINS-1:REG_W]  <= wdata[UPW-1:0];
        A_SELL_LO: lo_q[REG_W-1:0]     <= wdata;
        A_SELL_UP: lo_q[NUM_PINS-1:REG_W]  <= wdata[UPW-1:0];
        A_DIR_LO:  dir_q[REG_W-1:0]    <= wdata;
        A_DIR_UP:  dir_q[NUM_PINS-1:REG_W] <= wdata[UPW-1:0];
        A_OUT_LO:  out_q[REG_W-1:0]    <= wdata;
        A_OUT_UP:  out_q[NUM_PINS-1:REG_W] <= wdata[UPW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (bad_any) err_q <= 1'b1;
    else if (clr_req) err_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_SELH_LO: rdata = hi_q[REG_W-1:0];
      A_SELH_UP: rdata = REG_W'(hi_q[NUM_PINS-1:REG_W]);
      A_SELL_LO: rdata = lo_q[REG_W-1:0];
      A_SELL_UP: rdata = REG_W'(lo_q[NUM_PINS-1:REG_W]);
      A_DIR_LO:  rdata = dir_q[REG_W-1:0];
      A_DIR_UP:  rdata = REG_W'(dir_q[NUM_PINS-1:REG_W]);
      A_OUT_LO:  rdata = port_view[REG_W-1:0];
      A_OUT_UP:  rdata = REG_W'(port_view[NUM_PINS-1:REG_W]);
      A_STATUS:  rdata = REG_W'(err_q);
      default:   rdata = '0;
    endcase
  end

  assign sel_hi = hi_q;
  assign sel_lo = lo_q;
  assign dir    = dir_q;
  assign outl   = out_q;
  assign err    = err_q;

  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_any |=> err_q); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_req) |=> err_q); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_SELH_UP || addr == A_SELL_UP || addr == A_DIR_UP || addr == A_OUT_UP)
      |-> (rdata[REG_W-1:UPW] == '0)); // R8
  AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_DIR_LO) |=> (dir_q[REG_W-1:0] == $past(wdata))); // R9

endmodule

// File: rtl/pfc_lane.sv
module pfc_lane
  import pfc_pkg::*;
#(
  parameter int IDX    = 0,
  parameter int BUS_W  = 8,
  parameter int RX_PIN = 0,
  parameter int TX_PIN = 1
) (
  input  logic       hi,
  input  logic       lo,
  input  logic       dir,
  input  logic       outl,
  input  logic       bus_wr,
  input  logic       bus_do,
  input  logic       txd,
  input  logic       alt_do,
  input  logic       pin_i,
  output logic       oe,
  output logic       dout,
  output logic [1:0] sel,
  output logic       bus_i,
  output logic       alt_i
);

  localparam bit IS_BUS = (IDX < BUS_W);
  localparam bit IS_RX  = (IDX == RX_PIN);
  localparam bit IS_TX  = (IDX == TX_PIN);

  pin_fn_e code;
  assign code = pin_fn_e'({hi, lo});

  always_comb begin
    oe    = dir;
    dout  = outl;
    sel   = FN_PORT;
    bus_i = 1'b0;
    alt_i = 1'b0;
    case (code)
      FN_BUS: begin
        if (IS_BUS) begin
          oe    = bus_wr;
          dout  = bus_do;
          sel   = FN_BUS;
          bus_i = pin_i;
        end
      end
      FN_SER: begin
        sel = FN_SER;
        if (IS_TX) begin
          oe   = 1'b1;
          dout = txd;
        end else if (IS_RX) begin
          oe   = 1'b0;
          dout = 1'b0;
        end else begin
          oe    = dir;
          dout  = alt_do;
          alt_i = pin_i;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pin_function_ctrl.sv
module pin_function_ctrl
  import pfc_pkg::*;
#(
  parameter int NUM_PINS    = 22,
  parameter int BUS_W       = 8,
  parameter int RX_PIN      = 0,
  parameter int TX_PIN      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  boot_ext8,
  input  logic                  reg_we,
  input  logic [3:0]            reg_addr,
  input  logic [15:0]           reg_wdata,
  output logic [15:0]           reg_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [2*NUM_PINS-1:0] pin_sel,
  input  logic                  bus_wr,
  input  logic [BUS_W-1:0]      bus_dout,
  output logic [BUS_W-1:0]      bus_din,
  input  logic                  ser_txd,
  output logic                  ser_rxd,
  input  logic [NUM_PINS-1:0]   alt_dout,
  output logic [NUM_PINS-1:0]   alt_din
);

  logic [NUM_PINS-1:0] sel_hi, sel_lo, dir, outl, pin_sync, port_view;
  logic [NUM_PINS-1:0] lane_bus_i;
  logic                err;

  pfc_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  assign port_view = (dir & outl) | (~dir & pin_sync);

  pfc_regs #(.NUM_PINS(NUM_PINS), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .boot_ext8(boot_ext8),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .port_view(port_view),
    .sel_hi(sel_hi), .sel_lo(sel_lo), .dir(dir), .outl(outl), .err(err)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
    logic bdo;
    if (i < BUS_W) begin : g_bus
      assign bdo = bus_dout[i];
    end else begin : g_nobus
      assign bdo = 1'b0;
    end

    pfc_lane #(.IDX(i), .BUS_W(BUS_W), .RX_PIN(RX_PIN), .TX_PIN(TX_PIN)) u_lane (
      .hi(sel_hi[i]), .lo(sel_lo[i]), .dir(dir[i]), .outl(outl[i]),
      .bus_wr(bus_wr), .bus_do(bdo), .txd(ser_txd), .alt_do(alt_dout[i]),
      .pin_i(pin_in[i]),
      .oe(pin_oe[i]), .dout(pin_out[i]), .sel(pin_sel[2*i +: 2]),
      .bus_i(lane_bus_i[i]), .alt_i(alt_din[i])
    );

    AST_NO_BAD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      pin_sel[2*i +: 2] != 2'b11); // R6
  end

  assign bus_din = lane_bus_i[BUS_W-1:0];
  assign ser_rxd = (pin_sel[2*RX_PIN +: 2] == FN_SER) ? pin_in[RX_PIN] : 1'b1;

  AST_TX_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi[TX_PIN] && !sel_lo[TX_PIN]) |-> (pin_oe[TX_PIN] && pin_out[TX_PIN] == ser_txd)); // R4
  AST_RX_LISTENS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi[RX_PIN] && !sel_lo[RX_PIN]) |-> !pin_oe[RX_PIN]); // R4
  AST_NO_WIDE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    lane_bus_i[NUM_PINS-1:BUS_W] == '0); // R3
  AST_ERR_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_STATUS) |-> (reg_rdata == {15'd0, err})); // R6

endmodule

// File: tb/test_pin_function_ctrl.sv
module test_pin_function_ctrl;

  localparam int N = 22;

  typedef struct packed {
    logic [15:0] hi, lo, dir, outl;
    logic        bwr;
    logic [7:0]  bdo;
    logic        txd;
    logic [15:0] alt, eoe, edo;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'h0000, 16'h0000, 16'h00F0, 16'h00A5, 1'b1, 8'hFF, 1'b0, 16'hFFFF, 16'h00F0, 16'h00A5},
    '{16'h0000, 16'h00FF, 16'h0F0F, 16'h0000, 1'b1, 8'h3C, 1'b1, 16'h0000, 16'h0FFF, 16'h003C},
    '{16'h0000, 16'h00FF, 16'h0F0F, 16'h0000, 1'b0, 8'h3C, 1'b1, 16'h0000, 16'h0F00, 16'h003C},
    '{16'h0003, 16'h0000, 16'h0011, 16'h00F0, 1'b1, 8'hFF, 1'b1, 16'h0000, 16'h0012, 16'h00F2},
    '{16'h0300, 16'h0400, 16'h0500, 16'h0400, 1'b1, 8'h00, 1'b0, 16'h0300, 16'h0500, 16'h0700},
    '{16'h0004, 16'h0004, 16'h0004, 16'h0000, 1'b1, 8'hFF, 1'b1, 16'h0000, 16'h0004, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          boot_ext8 = 1'b0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = 4'd0;
  logic [15:0]   reg_wdata = 16'd0;
  logic [15:0]   reg_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_oe, pin_out, alt_din;
  logic [2*N-1:0] pin_sel;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_dout = 8'd0;
  logic [7:0]    bus_din;
  logic          ser_txd = 1'b0;
  logic          ser_rxd;
  logic [N-1:0]  alt_dout = '0;

  int total = 0;
  int bad = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  pin_function_ctrl i_pin_function_ctrl (
    .clk(clk), .rst_n(rst_n), .boot_ext8(boot_ext8),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_sel(pin_sel),
    .bus_wr(bus_wr), .bus_dout(bus_dout), .bus_din(bus_din),
    .ser_txd(ser_txd), .ser_rxd(ser_rxd),
    .alt_dout(alt_dout), .alt_din(alt_din)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, normal boot
    rd(4'd2, rv); check("R1 sel low reset", rv, 16'h0000);
    rd(4'd4, rv); check("R1 dir reset", rv, 16'h0000);
    rd(4'd8, rv); check("R1 status reset", rv, 16'h0000);
    check("R1 oe reset", pin_oe, 0);

    // vector table: R2 R3 R4 R5 R7
    for (int v = 0; v < 6; v++) begin
      wr(4'd0, VECS[v].hi);
      wr(4'd2, VECS[v].lo);
      wr(4'd4, VECS[v].dir);
      wr(4'd6, VECS[v].outl);
      bus_wr = VECS[v].bwr; bus_dout = VECS[v].bdo;
      ser_txd = VECS[v].txd; alt_dout = {6'd0, VECS[v].alt};
      @(negedge clk);
      check("R2/R3/R4/R5/R7 table oe", pin_oe, {6'd0, VECS[v].eoe});
      check("R2/R3/R4/R5/R7 table out", pin_out, {6'd0, VECS[v].edo});
    end

    // R6 forbidden code on pin 2 behaves as port and raises flag
    check("R6 sel of bad pin", pin_sel[5:4], 2'b00);
    rd(4'd8, rv); check("R6 flag set", rv, 16'h0001);
    wr(4'd8, 16'h0001);
    rd(4'd8, rv); check("R6 clear blocked while bad", rv, 16'h0001);
    wr(4'd2, 16'h0000);
    rd(4'd8, rv); check("R6 flag sticky", rv, 16'h0001);
    wr(4'd8, 16'h0000);
    rd(4'd8, rv); check("R6 write 0 keeps", rv, 16'h0001);
    wr(4'd8, 16'h0001);
    rd(4'd8, rv); check("R6 cleared", rv, 16'h0000);

    // R8 upper registers
    wr(4'd0, 16'h0000);
    wr(4'd5, 16'hFFFF);
    rd(4'd5, rv); check("R8 upper dir masked", rv, 16'h003F);
    check("R8 upper pins drive", pin_oe[21:16], 6'h3F);
    wr(4'd1, 16'hFFC0);
    rd(4'd1, rv); check("R8 upper sel ignores high bits", rv, 16'h0000);
    wr(4'd5, 16'h0000);

    // R9 write timing
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd4; reg_wdata = 16'h1234;
    #1;
    check("R9 old value before edge", reg_rdata, 16'h0004);
    @(negedge clk);
    reg_we = 1'b0;
    #1;
    check("R9 new value after edge", reg_rdata, 16'h1234);

    // R10 port readback
    wr(4'd4, 16'h0000);
    wr(4'd6, 16'h0000);
    pin_in = '0;
    repeat (3) @(negedge clk);
    pin_in[3] = 1'b1;
    reg_addr = 4'd6;
    @(negedge clk);
    check("R10 one edge not yet", reg_rdata[3], 1'b0);
    @(negedge clk);
    check("R10 synced level", reg_rdata[3], 1'b1);
    wr(4'd4, 16'h0008);
    rd(4'd6, rv); check("R10 output pin reads latch", rv[3], 1'b0);
    wr(4'd4, 16'h0000);
    pin_in = '0;

    // R4 receive routing
    wr(4'd0, 16'h0001);
    pin_in[0] = 1'b0; #1;
    check("R4 rxd low", ser_rxd, 1'b0);
    pin_in[0] = 1'b1; #1;
    check("R4 rxd high", ser_rxd, 1'b1);
    pin_in[0] = 1'b0;
    wr(4'd0, 16'h0000);
    check("R4 rxd idle when unselected", ser_rxd, 1'b1);

    // R3 bus input
    wr(4'd2, 16'h0020);
    pin_in = 22'h000020; #1;
    check("R3 bus din", bus_din, 8'h20);
    check("R3 sel bus", pin_sel[11:10], 2'b01);
    wr(4'd2, 16'h0000);
    check("R3 bus din zero in port", bus_din, 8'h00);

    // R5 alternate input
    wr(4'd0, 16'h0100);
    pin_in = 22'h000100; #1;
    check("R5 alt din", alt_din, 22'h000100);
    check("R5 sel alt", pin_sel[17:16], 2'b10);
    wr(4'd0, 16'h0000);
    check("R5 alt din zero in port", alt_din, 22'h0);
    pin_in = '0;

    // R1 boot into external bus
    @(negedge clk);
    rst_n = 1'b0; boot_ext8 = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'd2, rv); check("R1 boot sel low", rv, 16'h00FF);
    rd(4'd0, rv); check("R1 boot sel high", rv, 16'h0000);
    check("R1 boot pin0 bus", pin_sel[1:0], 2'b01);
    check("R1 boot pin8 port", pin_sel[17:16], 2'b00);

    finish_run();
  end

endmodule